// File: doc/BRIEF.md
# Staged Descriptor Table Access

This block holds a table of ring descriptors, for example the entries of a set of event queues, and gives a simple register interface an untorn view of them. Every entry has five fields: a head index, a tail index, a control word, a base address and a combined size/sequence word. Software never reaches the table one field at a time. It loads a set of write staging registers and an entry address, then writes a commit trigger, and all five fields land in the addressed entry on the same clock edge.

Reads work the other way round. A capture trigger copies the whole addressed entry into read staging registers on one edge. Software can then read those registers one by one and see a consistent snapshot, even while the live entry keeps changing. Two narrower paths bypass the staging registers. A direct head write updates only the head index of the addressed entry. A hardware tail port lets the queue producer advance a tail index. A software commit to the same entry in the same cycle overrides that port.

Top module: `desc_table_access`

## Requirements
- R1: Reset clears every table entry, every write and read staging register and the address register to zero.
- R2: Register selectors written through `wr_sel` are: 0 head stage, 1 tail stage, 2 control stage, 3 base stage, 4 size/sequence stage, 5 entry address, 6 commit trigger, 7 capture trigger, 8 to 12 read snapshot of head, tail, control, base and size/sequence, 13 direct head write, 14 status. Head and tail are 8 bits, control is 16 bits, base and size/sequence are 32 bits, and the address register is 5 bits. Each is taken from the low bits of `wr_data`, and `rd_data` returns it zero-extended at the same selector.
- R3: A write to selector 6 stores all five staged fields into the addressed entry on that clock edge.
- R4: A write to selector 7 copies all five fields of the addressed entry into the read snapshot on that clock edge.
- R5: The read snapshot does not change until the next capture, even when the entry it came from is rewritten.
- R6: A write to selector 13 sets the head index of the addressed entry to `wr_data[7:0]` and leaves its other four fields unchanged.
- R7: When the address register holds a value at or above the table depth (16), a commit or a direct head write changes no entry, and a capture loads zeros into all five snapshot fields.
- R8: With `hw_tail_we` high, the tail of entry `hw_tail_idx` becomes `hw_tail_val` on that edge. An index at or above the depth is ignored.
- R9: If a commit and a hardware tail update target the same entry in one cycle, the staged tail is stored. If they target different entries, both take effect.
- R10: `busy` is always 0, and bit 0 of status selector 14 reads 0, because every operation completes in one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register selector for the write |
| wr_data | input | 32 | Register write data |
| rd_sel | input | 4 | Register selector for the combinational read |
| rd_data | output | 32 | Read data for `rd_sel` |
| hw_tail_we | input | 1 | Hardware tail update strobe |
| hw_tail_idx | input | 5 | Entry index for the tail update |
| hw_tail_val | input | 8 | New tail index |
| busy | output | 1 | Operation in progress (always 0) |

## Verification
The checker checks, on every cycle, that a commit lands all staged fields in the table. It also checks that a capture reproduces the addressed entry or zeros, that the snapshot holds between captures, that a direct head write and a tail update reach their fields, and that a commit wins over a colliding tail update. Some behaviours show only at the ports and are left to the bench scenarios: the selector map and field truncation, the effect of reset on every entry, and the absence of side effects from out-of-range addresses on neighbouring entries. A full sweep over all sixteen entries exercises every address decode.

// File: rtl/desc_pkg.sv
package desc_pkg;
  localparam int IDX_W  = 8;
  localparam int CTRL_W = 16;
  localparam int BASE_W = 32;
  localparam int SZ_W   = 32;
  localparam int DATA_W = 32;
  localparam int SEL_W  = 4;

  typedef struct packed {
    logic [IDX_W-1:0]  head;
    logic [IDX_W-1:0]  tail;
    logic [CTRL_W-1:0] ctrl;
    logic [BASE_W-1:0] base;
    logic [SZ_W-1:0]   szseq;
  } desc_t;

  typedef enum logic [SEL_W-1:0] {
    S_WHEAD   = 4'd0,
    S_WTAIL   = 4'd1,
    S_WCTRL   = 4'd2,
    S_WBASE   = 4'd3,
    S_WSIZE   = 4'd4,
    S_ADDR    = 4'd5,
    S_WTRIG   = 4'd6,
    S_RTRIG   = 4'd7,
    S_RHEAD   = 4'd8,
    S_RTAIL   = 4'd9,
    S_RCTRL   = 4'd10,
    S_RBASE   = 4'd11,
    S_RSIZE   = 4'd12,
    S_HEADDIR = 4'd13,
    S_STATUS  = 4'd14
  } sel_e;

  // True when an entry number falls inside a table of the given depth.
  function automatic logic in_range(input logic [31:0] a, input int depth);
    return a < 32'(depth);
  endfunction

  // Field f (0 head .. 4 size/sequence) of a descriptor, zero-extended.
  function automatic logic [DATA_W-1:0] field_word(input desc_t d, input logic [2:0] f);
    case (f)
      3'd0:    return DATA_W'(d.head);
      3'd1:    return DATA_W'(d.tail);
      3'd2:    return DATA_W'(d.ctrl);
      3'd3:    return DATA_W'(d.base);
      3'd4:    return DATA_W'(d.szseq);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/desc_regif.sv
module desc_regif
  import desc_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output desc_t             stage,
  output logic [AW-1:0]     addr,
  output logic              commit_req,
  output logic              capture_req,
  output logic              head_req,
  output logic [IDX_W-1:0]  head_val
);
  assign commit_req  = wr_en && (wr_sel == S_WTRIG);
  assign capture_req = wr_en && (wr_sel == S_RTRIG);
  assign head_req    = wr_en && (wr_sel == S_HEADDIR);
  assign head_val    = wr_data[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage <= '0;
      addr  <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        S_WHEAD: stage.head  <= wr_data[IDX_W-1:0];
        S_WTAIL: stage.tail  <= wr_data[IDX_W-1:0];
        S_WCTRL: stage.ctrl  <= wr_data[CTRL_W-1:0];
        S_WBASE: stage.base  <= wr_data[BASE_W-1:0];
        S_WSIZE: stage.szseq <= wr_data[SZ_W-1:0];
        S_ADDR:  addr        <= wr_data[AW-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/desc_store.sv
module desc_store
  import desc_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit_req,
  input  logic             head_req,
  input  logic [IDX_W-1:0] head_val,
  input  logic [AW-1:0]    addr,
  input  desc_t            stage,
  input  logic             hw_we,
  input  logic [AW-1:0]    hw_idx,
  input  logic [IDX_W-1:0] hw_val,
  output desc_t            tbl [DEPTH],
  output desc_t            sel_entry,
  output logic             addr_ok,
  output logic             commit_fire,
  output logic             head_fire,
  output logic             hw_tail_fire
);
  localparam int LW = $clog2(DEPTH);

  logic hw_ok;

  assign addr_ok      = in_range(32'(addr), DEPTH);
  assign hw_ok        = in_range(32'(hw_idx), DEPTH);
  assign commit_fire  = commit_req && addr_ok;
  assign head_fire    = head_req && addr_ok;
  assign hw_tail_fire = hw_we && hw_ok;
  assign sel_entry    = addr_ok ? tbl[addr[LW-1:0]] : '0;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic hit_commit, hit_head, hit_hw;
    assign hit_commit = commit_fire && (addr == AW'(i));
    assign hit_head   = head_fire && (addr == AW'(i));
    assign hit_hw     = hw_tail_fire && (hw_idx == AW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tbl[i] <= '0;
      end else if (hit_commit) begin
        tbl[i] <= stage;
      end else begin
        if (hit_head) tbl[i].head <= head_val;
        if (hit_hw)   tbl[i].tail <= hw_val;
      end
    end
  end
endmodule

// File: rtl/desc_snap.sv
module desc_snap
  import desc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  capture_req,
  input  desc_t sel_entry,
  output desc_t snap
);
  always_ff @(posedge clk) begin
    if (!rst_n)           snap <= '0;
    else if (capture_req) snap <= sel_entry;
  end
endmodule

// File: rtl/desc_table_access.sv
module desc_table_access
  import desc_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH) + 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [3:0]  rd_sel,
  output logic [31:0] rd_data,
  input  logic        hw_tail_we,
  input  logic [4:0]  hw_tail_idx,
  input  logic [7:0]  hw_tail_val,
  output logic        busy
);
  desc_t            stage, snap, sel_entry;
  desc_t            tbl [DEPTH];
  logic [AW-1:0]    addr;
  logic             commit_req, capture_req, head_req;
  logic [IDX_W-1:0] head_val;
  logic             addr_ok, commit_fire, head_fire, hw_tail_fire;

  desc_regif #(.AW(AW)) u_regif (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .stage(stage), .addr(addr), .commit_req(commit_req), .capture_req(capture_req),
    .head_req(head_req), .head_val(head_val)
  );

  desc_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .commit_req(commit_req), .head_req(head_req),
    .head_val(head_val), .addr(addr), .stage(stage), .hw_we(hw_tail_we),
    .hw_idx(AW'(hw_tail_idx)), .hw_val(hw_tail_val), .tbl(tbl), .sel_entry(sel_entry),
    .addr_ok(addr_ok), .commit_fire(commit_fire), .head_fire(head_fire),
    .hw_tail_fire(hw_tail_fire)
  );

  desc_snap u_snap (
    .clk(clk), .rst_n(rst_n), .capture_req(capture_req), .sel_entry(sel_entry), .snap(snap)
  );

  // Every operation finishes in the cycle it is requested.
  assign busy = 1'b0;

  always_comb begin
    case (rd_sel)
      S_WHEAD, S_WTAIL, S_WCTRL, S_WBASE, S_WSIZE:
        rd_data = field_word(stage, rd_sel[2:0]);
      S_ADDR:
        rd_data = DATA_W'(addr);
      S_RHEAD, S_RTAIL, S_RCTRL, S_RBASE, S_RSIZE:
        rd_data = field_word(snap, 3'(rd_sel - 4'd8));
      S_STATUS:
        rd_data = DATA_W'(busy);
      default:
        rd_data = '0;
    endcase
  end
endmodule

// File: rtl/desc_table_chk.sv
module desc_table_chk
  import desc_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             commit_fire,
  input logic             capture_req,
  input logic             head_fire,
  input logic             hw_tail_fire,
  input logic             addr_ok,
  input logic [AW-1:0]    addr,
  input logic [4:0]       hw_tail_idx,
  input logic [IDX_W-1:0] hw_tail_val,
  input logic [IDX_W-1:0] head_val,
  input desc_t            stage,
  input desc_t            sel_entry,
  input desc_t            snap,
  input desc_t            tbl [DEPTH]
);
  localparam int LW = $clog2(DEPTH);

  logic same_idx;
  assign same_idx = (AW'(hw_tail_idx) == addr);

  p_commit_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |=> tbl[$past(addr[LW-1:0])] == $past(stage));

  p_capture_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    capture_req && addr_ok |=> snap == $past(sel_entry));

  p_snap_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_req |=> $stable(snap));

  p_head_direct_r6: assert property (@(posedge clk) disable iff (!rst_n)
    head_fire |=> tbl[$past(addr[LW-1:0])].head == $past(head_val));

  p_capture_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    capture_req && !addr_ok |=> snap == '0);

  p_hw_tail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hw_tail_fire && !(commit_fire && same_idx)
      |=> tbl[$past(hw_tail_idx[LW-1:0])].tail == $past(hw_tail_val));

  p_commit_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hw_tail_fire && commit_fire && same_idx
      |=> tbl[$past(hw_tail_idx[LW-1:0])].tail == $past(stage.tail));
endmodule

bind desc_table_access desc_table_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .commit_fire(commit_fire), .capture_req(capture_req),
  .head_fire(head_fire), .hw_tail_fire(hw_tail_fire), .addr_ok(addr_ok), .addr(addr),
  .hw_tail_idx(hw_tail_idx), .hw_tail_val(hw_tail_val), .head_val(head_val),
  .stage(stage), .sel_entry(sel_entry), .snap(snap), .tbl(tbl)
);

// File: tb/sim_desc_table_access.sv
module sim_desc_table_access;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        hw_tail_we = 1'b0;
  logic [4:0]  hw_tail_idx = '0;
  logic [7:0]  hw_tail_val = '0;
  logic        busy;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  desc_table_access #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .hw_tail_we(hw_tail_we),
    .hw_tail_idx(hw_tail_idx), .hw_tail_val(hw_tail_val), .busy(busy)
  );

  // Expected fields, widths as stated in R2: head, tail (8), ctrl (16), base, size (32).
  function automatic logic [31:0] pat(input int e, input int f, input int salt);
    case (f)
      0: return 32'((e * 7 + 3 + salt) & 8'hFF);
      1: return 32'((e * 13 + 1 + salt) & 8'hFF);
      2: return 32'((16'hA000 | e) + salt) & 32'hFFFF;
      3: return 32'h1000_0000 + 32'(e * 64) + 32'(salt);
      default: return {16'(e + salt), 16'h0100 + 16'(e)};
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 4'(sel); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int sel, output logic [31:0] d);
    rd_sel = 4'(sel);
    #1 d = rd_data;
  endtask

  task automatic commit(input int e, input int salt);
    for (int f = 0; f < 5; f++) wr(f, pat(e, f, salt));
    wr(5, 32'(e));
    wr(6, 32'h0);
  endtask

  task automatic capture(input logic [31:0] a);
    wr(5, a);
    wr(7, 32'h0);
  endtask

  task automatic chk_snap(input string tag, input logic [31:0] exp [5]);
    logic [31:0] v;
    for (int f = 0; f < 5; f++) begin
      rd(8 + f, v);
      chk(tag, v, exp[f]);
    end
  endtask

  task automatic chk_entry(input string tag, input int e, input int salt);
    logic [31:0] exp [5];
    capture(32'(e));
    for (int f = 0; f < 5; f++) exp[f] = pat(e, f, salt);
    chk_snap(tag, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] zz [5];
    logic [31:0] ex [5];
    for (int f = 0; f < 5; f++) zz[f] = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: every readable register is zero after reset
    for (int s = 0; s < 15; s++) begin
      rd(s, v);
      chk("R1 reg after reset", v, 32'h0);
    end
    // R1: every entry is zero after reset
    for (int e = 0; e < DEPTH; e++) begin
      capture(32'(e));
      chk_snap("R1 entry after reset", zz);
    end

    // R2: staging and address readback with truncation to field width
    wr(0, 32'h1234_5678); rd(0, v); chk("R2 head stage", v, 32'h78);
    wr(1, 32'hFFFF_FF9A); rd(1, v); chk("R2 tail stage", v, 32'h9A);
    wr(2, 32'hDEAD_BEEF); rd(2, v); chk("R2 ctrl stage", v, 32'hBEEF);
    wr(3, 32'hCAFE_F00D); rd(3, v); chk("R2 base stage", v, 32'hCAFE_F00D);
    wr(4, 32'h0BAD_1DEA); rd(4, v); chk("R2 size stage", v, 32'h0BAD_1DEA);
    wr(5, 32'hFFFF_FFE3); rd(5, v); chk("R2 addr reg", v, 32'h03);

    // R3, R4: sweep every entry with distinct contents, then read all back
    for (int e = 0; e < DEPTH; e++) commit(e, 0);
    for (int e = 0; e < DEPTH; e++) chk_entry("R3 R4 sweep", e, 0);

    // R5: snapshot holds while its source entry is rewritten
    capture(32'd2);
    commit(2, 5);
    for (int f = 0; f < 5; f++) ex[f] = pat(2, f, 0);
    chk_snap("R5 snapshot hold", ex);
    chk_entry("R5 recapture", 2, 5);

    // R6: direct head write touches only head
    wr(5, 32'd9);
    wr(13, 32'hFFFF_FF5C);
    capture(32'd9);
    for (int f = 0; f < 5; f++) ex[f] = pat(9, f, 0);
    ex[0] = 32'h5C;
    chk_snap("R6 direct head", ex);

    // R7: out-of-range commit and head write ignored, capture yields zeros
    for (int f = 0; f < 5; f++) wr(f, 32'hFFFF_FFFF);
    wr(5, 32'd16); wr(6, 32'h0); wr(13, 32'h77);
    wr(5, 32'd31); wr(6, 32'h0); wr(13, 32'h77);
    chk_entry("R7 entry 0 untouched", 0, 0);
    chk_entry("R7 entry 15 untouched", 15, 0);
    capture(32'd20);
    chk_snap("R7 oob capture zero", zz);

    // R8: hardware tail update, in range and out of range
    @(negedge clk);
    hw_tail_we = 1'b1; hw_tail_idx = 5'd3; hw_tail_val = 8'hC3;
    @(negedge clk);
    hw_tail_idx = 5'd17; hw_tail_val = 8'h11;
    @(negedge clk);
    hw_tail_we = 1'b0;
    capture(32'd3);
    for (int f = 0; f < 5; f++) ex[f] = pat(3, f, 0);
    ex[1] = 32'hC3;
    chk_snap("R8 hw tail", ex);
    chk_entry("R8 oob hw tail ignored", 1, 0);

    // R9: commit and tail update collide on entry 5
    for (int f = 0; f < 5; f++) wr(f, pat(5, f, 9));
    wr(5, 32'd5);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 4'd6;
    hw_tail_we = 1'b1; hw_tail_idx = 5'd5; hw_tail_val = 8'hEE;
    @(negedge clk);
    wr_en = 1'b0; hw_tail_we = 1'b0;
    chk_entry("R9 commit wins", 5, 9);

    // R9: commit to entry 6 while tail of entry 7 moves
    for (int f = 0; f < 5; f++) wr(f, pat(6, f, 4));
    wr(5, 32'd6);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 4'd6;
    hw_tail_we = 1'b1; hw_tail_idx = 5'd7; hw_tail_val = 8'h42;
    @(negedge clk);
    wr_en = 1'b0; hw_tail_we = 1'b0;
    chk_entry("R9 commit other entry", 6, 4);
    capture(32'd7);
    for (int f = 0; f < 5; f++) ex[f] = pat(7, f, 0);
    ex[1] = 32'h42;
    chk_snap("R9 tail other entry", ex);

    // R10: never busy
    rd(14, v);
    chk("R10 status", v, 32'h0);
    chk("R10 busy port", 32'(busy), 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule